// File: doc/BRIEF.md
# Linear Sensor Drive Timing Generator

This block produces the digital drive waveforms for a cooled 516-pixel linear infrared readout chip that runs with integration overlapping readout. From the system clock it derives a pixel clock, an acquisition-period signal, three sampling strobes, a readout trigger pulse, and a static 3-bit gain code. The acquisition period repeats while the start control is high. Each period is an acquisition-high interval followed by an acquisition-low interval. The strobes and the trigger are placed at fixed or programmed cycle offsets inside that period.

Software sets the pixel clock half-period, the acquisition high and low widths, the integration time and the gain code. All of these are given in system clock cycles. The generator copies them into its working set only when a new period begins. If the integration window cannot fit inside the high interval, or the divider is zero, the period still runs, but every drive line stays at its initial level and an invalid flag is raised. The strobe widths, the second-strobe lead before the acquisition-low edge, the first and third strobe rise offsets, the minimum low width and the trigger position are elaboration parameters.

Top module: `lin_sensor_timing`

## Requirements
- R1: While `start_i` is low, and from the cycle after it is sampled low, the outputs hold their initial levels: `acq_rst_o` high, and `pclk_o`, `samp1_o`, `samp2_o`, `samp3_o`, `trig_o`, `busy_o` and `timing_bad_o` low.
- R2: Within a period, at position t (t = 0 being the first cycle of the period), `pclk_o` equals bit 0 of floor(t / D), where D is the latched half-period. The pixel clock therefore restarts low at every period.
- R3: `acq_rst_o` is high for t < H and low for the rest of the period. The low interval lasts max(L, MIN_LOW) cycles, so any shorter low setting is clamped.
- R4: `samp1_o` is high for SH1_RISE <= t < H - LEAD + SH_W - I. This makes the integration time, from the falling edge of strobe 1 to the falling edge of strobe 2, exactly I cycles, and strobe 1 rises while strobes 2 and 3 are low.
- R5: `samp2_o` is high for SH_W cycles starting at t = H - LEAD. `samp3_o` is high for SH_W cycles starting at t = SH3_RISE. Strobe 2 is low again before `acq_rst_o` falls.
- R6: `trig_o` rises at t = 2*ST_PCLK*D + floor(D/2), which is mid-way through a pixel-clock low phase, and stays high for 2*D cycles.
- R7: The half-period, high width, low width, integration time and gain code are captured only when a period begins (at start and at each period wrap). Input changes made mid-period take effect at the next period.
- R8: A parameter set with I = 0, D = 0, or I + LEAD + SH1_RISE > H is invalid. During such a period `timing_bad_o` and `busy_o` are high, all drive lines stay at their initial levels, and the period length is still H + max(L, MIN_LOW).
- R9: `gain_sel_o` drives the latched 3-bit code as a static level. 3'b111 selects the highest gain. The code is 3'b000 after reset and is held while stopped.
- R10: Period position 0 reaches the drive outputs two clock edges after `start_i` is first sampled high, and `busy_o` is high from that same cycle.
- R11: Stopping mid-period and starting again begins a fresh period at position 0, with newly latched settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Run control; low forces initial levels |
| div_half_i | input | CNT_W | Pixel clock half-period in system cycles |
| acq_high_i | input | CNT_W | Acquisition-high width in system cycles |
| acq_low_i | input | CNT_W | Acquisition-low width request (clamped to MIN_LOW) |
| integ_i | input | CNT_W | Integration time in system cycles |
| gain_i | input | 3 | Gain code request |
| pclk_o | output | 1 | Pixel clock |
| acq_rst_o | output | 1 | Acquisition-period signal, idles high |
| samp1_o | output | 1 | Sampling strobe 1 (integration start on fall) |
| samp2_o | output | 1 | Sampling strobe 2 (integration end on fall) |
| samp3_o | output | 1 | Sampling strobe 3 |
| trig_o | output | 1 | Readout trigger pulse |
| gain_sel_o | output | 3 | Latched static gain code |
| busy_o | output | 1 | A period is running |
| timing_bad_o | output | 1 | Latched parameter set is invalid |

## Verification
The hardest case to reach from the ports is a settings change that arrives in the middle of a running period. Only the period wrap may pick it up, so the stimulus changes every input a thousand cycles into the first period. The expected waveform switches to the new settings exactly at the wrap, with the gain code switching one cycle ahead of the drive lines. The stimulus also places the integration time exactly on the validity boundary, uses a one-cycle pixel half-period where the trigger midpoint collapses onto the low-phase start, and stops and restarts the generator in the middle of a period.

// File: rtl/lst_pkg.sv
package lst_pkg;

   typedef struct packed {
      logic pclk;
      logic acq;
      logic s1;
      logic s2;
      logic s3;
      logic trig;
   } lst_drv_t;

   localparam lst_drv_t DRV_IDLE = '{pclk: 1'b0, acq: 1'b1, s1: 1'b0,
                                     s2: 1'b0, s3: 1'b0, trig: 1'b0};

endpackage

// File: rtl/lst_period_ctr.sv
module lst_period_ctr #(
   parameter int CNT_W   = 16,
   parameter int MIN_LOW = 200,
   parameter int PW      = CNT_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] div_half_i,
   input  logic [CNT_W-1:0] acq_high_i,
   input  logic [CNT_W-1:0] acq_low_i,
   input  logic [CNT_W-1:0] integ_i,
   input  logic [2:0]       gain_i,
   output logic             running_o,
   output logic             load_o,
   output logic [PW-1:0]    pos_o,
   output logic [CNT_W-1:0] div_q_o,
   output logic [CNT_W-1:0] high_q_o,
   output logic [CNT_W-1:0] integ_q_o,
   output logic [2:0]       gain_q_o
);

   logic [PW-1:0] low_eff;
   logic [PW-1:0] plen_d;
   logic [PW-1:0] plen_q;
   logic [PW-1:0] pos_q;
   logic          run_q;

   // clamp the low interval to its minimum
   always_comb begin
      low_eff = (PW'(acq_low_i) < PW'(MIN_LOW)) ? PW'(MIN_LOW) : PW'(acq_low_i);
      plen_d  = PW'(acq_high_i) + low_eff;
      load_o  = start_i && (!run_q || (pos_q == plen_q - 1'b1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q     <= 1'b0;
         pos_q     <= '0;
         plen_q    <= PW'(1);
         div_q_o   <= '0;
         high_q_o  <= '0;
         integ_q_o <= '0;
         gain_q_o  <= 3'b000;
      end else if (!start_i) begin
         run_q <= 1'b0;
         pos_q <= '0;
      end else if (load_o) begin
         run_q     <= 1'b1;
         pos_q     <= '0;
         plen_q    <= plen_d;
         div_q_o   <= div_half_i;
         high_q_o  <= acq_high_i;
         integ_q_o <= integ_i;
         gain_q_o  <= gain_i;
      end else begin
         pos_q <= pos_q + 1'b1;
      end
   end

   assign running_o = run_q;
   assign pos_o     = pos_q;

endmodule

// File: rtl/lst_pix_phase.sv
module lst_pix_phase #(
   parameter int CNT_W   = 16,
   parameter int ST_PCLK = 4,
   parameter bit ST_MID  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] div_i,
   output logic             pclk_o,
   output logic             trig_o
);

   localparam logic [CNT_W-1:0] HA = CNT_W'(2 * ST_PCLK);
   localparam logic [CNT_W-1:0] HB = CNT_W'(2 * ST_PCLK + 1);
   localparam logic [CNT_W-1:0] HC = CNT_W'(2 * ST_PCLK + 2);

   logic [CNT_W-1:0] dcnt_q;
   logic [CNT_W-1:0] hidx_q;
   logic [CNT_W-1:0] off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt_q <= '0;
         hidx_q <= '0;
      end else if (load_i) begin
         dcnt_q <= '0;
         hidx_q <= '0;
      end else if (div_i != '0) begin
         if (dcnt_q == div_i - 1'b1) begin
            dcnt_q <= '0;
            if (hidx_q != '1) hidx_q <= hidx_q + 1'b1;
         end else begin
            dcnt_q <= dcnt_q + 1'b1;
         end
      end
   end

   // trigger placement inside the low phase
   generate
      if (ST_MID) begin : g_mid
         assign off = div_i >> 1;
      end else begin : g_early
         assign off = '0;
      end
   endgenerate

   always_comb begin
      pclk_o = hidx_q[0];
      trig_o = ((hidx_q == HA) && (dcnt_q >= off)) ||
               (hidx_q == HB) ||
               ((hidx_q == HC) && (dcnt_q < off));
   end

endmodule

// File: rtl/lst_strobe_dec.sv
module lst_strobe_dec #(
   parameter int CNT_W    = 16,
   parameter int PW       = CNT_W + 1,
   parameter int SH_W     = 400,
   parameter int LEAD     = 500,
   parameter int SH1_RISE = 600,
   parameter int SH3_RISE = 100
) (
   input  logic [PW-1:0]    pos_i,
   input  logic [CNT_W-1:0] high_i,
   input  logic [CNT_W-1:0] integ_i,
   input  logic [CNT_W-1:0] div_i,
   output logic             acq_o,
   output logic             s1_o,
   output logic             s2_o,
   output logic             s3_o,
   output logic             valid_o
);

   localparam int EW = CNT_W + 2;

   logic [EW-1:0] pos_e, hi_e, int_e, need_e, s2_on, s1_off;

   always_comb begin
      pos_e   = EW'(pos_i);
      hi_e    = EW'(high_i);
      int_e   = EW'(integ_i);
      need_e  = int_e + EW'(LEAD + SH1_RISE);
      valid_o = (integ_i != '0) && (div_i != '0) && (need_e <= hi_e);
      s2_on   = hi_e - EW'(LEAD);
      s1_off  = s2_on + EW'(SH_W) - int_e;
      acq_o   = pos_e < hi_e;
      s1_o    = (pos_e >= EW'(SH1_RISE)) && (pos_e < s1_off);
      s2_o    = (pos_e >= s2_on) && (pos_e < s2_on + EW'(SH_W));
      s3_o    = (pos_e >= EW'(SH3_RISE)) && (pos_e < EW'(SH3_RISE + SH_W));
   end

endmodule

// File: rtl/lin_sensor_timing.sv
module lin_sensor_timing
   import lst_pkg::*;
#(
   parameter int CNT_W    = 16,
   parameter int MIN_LOW  = 200,
   parameter int SH_W     = 400,
   parameter int LEAD     = 500,
   parameter int SH1_RISE = 600,
   parameter int SH3_RISE = 100,
   parameter int ST_PCLK  = 4,
   parameter bit ST_MID   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] div_half_i,
   input  logic [CNT_W-1:0] acq_high_i,
   input  logic [CNT_W-1:0] acq_low_i,
   input  logic [CNT_W-1:0] integ_i,
   input  logic [2:0]       gain_i,
   output logic             pclk_o,
   output logic             acq_rst_o,
   output logic             samp1_o,
   output logic             samp2_o,
   output logic             samp3_o,
   output logic             trig_o,
   output logic [2:0]       gain_sel_o,
   output logic             busy_o,
   output logic             timing_bad_o
);

   localparam int PW = CNT_W + 1;

   // elaboration-time parameter checks
   generate
      if (MIN_LOW < 1) begin : g_err_low
         $error("MIN_LOW must be at least 1");
      end
      if (SH_W >= LEAD) begin : g_err_lead
         $error("strobe 2 must end before the acquisition-low edge");
      end
      if (SH3_RISE + SH_W > SH1_RISE) begin : g_err_ord
         $error("strobe 3 must end before strobe 1 rises");
      end
      if (2 * ST_PCLK + 2 >= (1 << CNT_W)) begin : g_err_trig
         $error("trigger position exceeds counter range");
      end
   endgenerate

   logic             running, load;
   logic [PW-1:0]    pos;
   logic [CNT_W-1:0] div_q, high_q, integ_q;
   logic             pclk_d, trig_d, acq_d, s1_d, s2_d, s3_d, valid;
   lst_drv_t         drv_d, drv_q;
   logic             busy_q, bad_q;

   lst_period_ctr #(.CNT_W(CNT_W), .MIN_LOW(MIN_LOW), .PW(PW)) u_per (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .div_half_i(div_half_i), .acq_high_i(acq_high_i), .acq_low_i(acq_low_i),
      .integ_i(integ_i), .gain_i(gain_i),
      .running_o(running), .load_o(load), .pos_o(pos),
      .div_q_o(div_q), .high_q_o(high_q), .integ_q_o(integ_q), .gain_q_o(gain_sel_o)
   );

   lst_pix_phase #(.CNT_W(CNT_W), .ST_PCLK(ST_PCLK), .ST_MID(ST_MID)) u_pix (
      .clk(clk), .rst_n(rst_n), .load_i(load), .div_i(div_q),
      .pclk_o(pclk_d), .trig_o(trig_d)
   );

   lst_strobe_dec #(.CNT_W(CNT_W), .PW(PW), .SH_W(SH_W), .LEAD(LEAD),
                    .SH1_RISE(SH1_RISE), .SH3_RISE(SH3_RISE)) u_dec (
      .pos_i(pos), .high_i(high_q), .integ_i(integ_q), .div_i(div_q),
      .acq_o(acq_d), .s1_o(s1_d), .s2_o(s2_d), .s3_o(s3_d), .valid_o(valid)
   );

   always_comb begin
      drv_d = DRV_IDLE;
      if (start_i && running && valid) begin
         drv_d = '{pclk: pclk_d, acq: acq_d, s1: s1_d, s2: s2_d, s3: s3_d, trig: trig_d};
      end
   end

   // registered drive lines: glitch-free outputs
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_q  <= DRV_IDLE;
         busy_q <= 1'b0;
         bad_q  <= 1'b0;
      end else begin
         drv_q  <= drv_d;
         busy_q <= start_i && running;
         bad_q  <= start_i && running && !valid;
      end
   end

   assign pclk_o       = drv_q.pclk;
   assign acq_rst_o    = drv_q.acq;
   assign samp1_o      = drv_q.s1;
   assign samp2_o      = drv_q.s2;
   assign samp3_o      = drv_q.s3;
   assign trig_o       = drv_q.trig;
   assign busy_o       = busy_q;
   assign timing_bad_o = bad_q;

endmodule

// File: rtl/lst_timing_chk.sv
module lst_timing_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic pclk_o,
   input logic acq_rst_o,
   input logic samp1_o,
   input logic samp2_o,
   input logic samp3_o,
   input logic trig_o,
   input logic busy_o,
   input logic timing_bad_o
);

   assert_idle_when_stopped_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (acq_rst_o && !pclk_o && !samp1_o && !samp2_o && !samp3_o &&
                    !trig_o && !busy_o && !timing_bad_o));

   assert_samp1_rise_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(samp1_o) |-> (!samp2_o && !samp3_o));

   assert_samp2_done_at_acq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(acq_rst_o) |-> (!samp2_o && !samp1_o));

   assert_trig_edges_in_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(trig_o) || $fell(trig_o)) |-> !pclk_o);

   assert_invalid_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      timing_bad_o |-> (acq_rst_o && !pclk_o && !samp1_o && !samp2_o && !samp3_o &&
                        !trig_o && busy_o));

endmodule

bind lin_sensor_timing lst_timing_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .pclk_o(pclk_o),
   .acq_rst_o(acq_rst_o), .samp1_o(samp1_o), .samp2_o(samp2_o),
   .samp3_o(samp3_o), .trig_o(trig_o), .busy_o(busy_o),
   .timing_bad_o(timing_bad_o)
);

// File: tb/lin_sensor_timing_test.sv
module lin_sensor_timing_test;

   localparam int CW   = 16;
   localparam int MINL = 200;
   localparam int SHW  = 400;
   localparam int LEAD = 500;
   localparam int S1R  = 600;
   localparam int S3R  = 100;
   localparam int KST  = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [CW-1:0] div_h = '0, hi = '0, lo = '0, integ = '0;
   logic [2:0]    gain = 3'b000;
   logic          pclk_o, acq_rst_o, samp1_o, samp2_o, samp3_o, trig_o, busy_o, timing_bad_o;
   logic [2:0]    gain_sel_o;

   always #5 clk = ~clk;

   lin_sensor_timing #(.CNT_W(CW), .MIN_LOW(MINL), .SH_W(SHW), .LEAD(LEAD),
                       .SH1_RISE(S1R), .SH3_RISE(S3R), .ST_PCLK(KST), .ST_MID(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start),
      .div_half_i(div_h), .acq_high_i(hi), .acq_low_i(lo), .integ_i(integ), .gain_i(gain),
      .pclk_o(pclk_o), .acq_rst_o(acq_rst_o), .samp1_o(samp1_o), .samp2_o(samp2_o),
      .samp3_o(samp3_o), .trig_o(trig_o), .gain_sel_o(gain_sel_o), .busy_o(busy_o),
      .timing_bad_o(timing_bad_o)
   );

   // scoreboard
   logic [10:0] exp_q[$];
   string       tag_q[$];
   int          compared = 0;
   int          mismatched = 0;
   bit          done = 1'b0;
   logic [2:0]  last_gain = 3'b000;

   int a_div, a_hi, a_lo, a_int, a_gain;
   int b_div, b_hi, b_lo, b_int, b_gain;
   int pa, pb;

   function automatic int plen(int h, int l);
      return h + ((l < MINL) ? MINL : l);
   endfunction

   // expected {gain, busy, bad, trig, s3, s2, s1, acq, pclk} at negedge k after start
   function automatic logic [10:0] expv(int k);
      logic [10:0] v;
      int g, t, d, h, i;
      bit ok;
      v = 11'b0;
      v[10:8] = 3'((k - 1 < pa) ? a_gain : b_gain);
      v[1] = 1'b1;
      if (k < 2) return v;
      g = k - 2;
      if (g < pa) begin
         t = g; d = a_div; h = a_hi; i = a_int;
      end else begin
         t = (g - pa) % pb; d = b_div; h = b_hi; i = b_int;
      end
      ok = (i > 0) && (d > 0) && (i + LEAD + S1R <= h);
      v[7] = 1'b1;
      v[6] = !ok;
      if (ok) begin
         v[0] = ((t / d) % 2) == 1;
         v[1] = t < h;
         v[2] = (t >= S1R) && (t < h - LEAD + SHW - i);
         v[3] = (t >= h - LEAD) && (t < h - LEAD + SHW);
         v[4] = (t >= S3R) && (t < S3R + SHW);
         v[5] = (t >= 2 * KST * d + d / 2) && (t < 2 * KST * d + d / 2 + 2 * d);
      end
      return v;
   endfunction

   function automatic string sig_req(logic [10:0] diff);
      if (diff[0]) return "R2 pclk";
      if (diff[1]) return "R3 acq";
      if (diff[2]) return "R4 samp1";
      if (diff[3]) return "R5 samp2";
      if (diff[4]) return "R5 samp3";
      if (diff[5]) return "R6 trig";
      if (diff[6]) return "R8 timing_bad";
      if (diff[7]) return "R10 busy";
      return "R9 gain";
   endfunction

   logic [10:0] mon_exp, mon_act;
   string       mon_tag;

   // monitor: pops one expectation per cycle, away from the clock edge
   always @(negedge clk) begin
      #1;
      if (exp_q.size() != 0) begin
         mon_exp = exp_q.pop_front();
         mon_tag = tag_q.pop_front();
         mon_act = {gain_sel_o, busy_o, timing_bad_o, trig_o, samp3_o, samp2_o,
                    samp1_o, acq_rst_o, pclk_o};
         compared++;
         if (mon_act !== mon_exp) begin
            mismatched++;
            $display("FAIL %s [%s] actual %b expected %b at %0t",
                     sig_req(mon_act ^ mon_exp), mon_tag, mon_act, mon_exp, $time);
         end
      end
   end

   task automatic apply(int d, int h, int l, int i, int g);
      div_h = CW'(d); hi = CW'(h); lo = CW'(l); integ = CW'(i); gain = 3'(g);
   endtask

   task automatic set_a(int d, int h, int l, int i, int g);
      a_div = d; a_hi = h; a_lo = l; a_int = i; a_gain = g;
      b_div = d; b_hi = h; b_lo = l; b_int = i; b_gain = g;
   endtask

   task automatic set_b(int d, int h, int l, int i, int g);
      b_div = d; b_hi = h; b_lo = l; b_int = i; b_gain = g;
   endtask

   // driver: starts the generator and pushes the expected waveform
   task automatic run_scn(string tg, int n, int chg);
      logic [10:0] v;
      apply(a_div, a_hi, a_lo, a_int, a_gain);
      pa = plen(a_hi, a_lo);
      pb = plen(b_hi, b_lo);
      start = 1'b1;
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         if (k == chg) apply(b_div, b_hi, b_lo, b_int, b_gain);
         v = expv(k);
         exp_q.push_back(v);
         tag_q.push_back(tg);
         last_gain = v[10:8];
      end
   endtask

   task automatic stop_scn(string tg, int n);
      start = 1'b0;
      for (int k = 1; k <= n; k++) begin
         @(negedge clk);
         exp_q.push_back({last_gain, 8'b0000_0010});
         tag_q.push_back(tg);
      end
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // reset state: idle levels, gain code zero (R1, R9)
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         exp_q.push_back(11'b000_0000_0010);
         tag_q.push_back("R1 R9 reset state");
      end

      // R7: mid-period change, low width clamp (R3), boundary-valid integration
      set_a(5, 3000, 100, 1000, 7);
      set_b(3, 2500, 400, 1400, 2);
      run_scn("R7 R3 R4 R10 reconfigure", 3200 + 2 * 2900 + 10, 1000);
      stop_scn("R1 stop holds idle", 20);

      // R8: integration one cycle too long
      set_a(5, 3000, 100, 1901, 3);
      run_scn("R8 integration overflow", 3300, 0);
      stop_scn("R1 stop after invalid", 10);

      // R8: zero divider
      set_a(0, 2000, 300, 200, 6);
      run_scn("R8 zero divider", 400, 0);
      stop_scn("R1 stop after zero divider", 5);

      // R11: stop mid-period, then restart from position 0
      set_a(4, 2000, 300, 300, 5);
      run_scn("R11 first run", 1500, 0);
      stop_scn("R11 stop mid-period", 5);
      set_a(4, 2000, 300, 300, 1);
      run_scn("R11 restart", 2500, 0);
      stop_scn("R1 stop after restart", 5);

      // R6 R2: one-cycle half-period, trigger midpoint collapses to low start
      set_a(1, 1200, 250, 100, 4);
      run_scn("R6 R2 single-cycle divider", 2700, 0);
      stop_scn("R1 final stop", 5);

      @(negedge clk);
      #3;
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         mismatched++;
         $display("FAIL watchdog: run did not complete, actual hung expected finished");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule